// File: doc/BRIEF.md
# Staged Clock Divider Ratio Register

This block holds the feedback ratio for a clock multiplier and runs the divide-by-N counter that uses that ratio. A host on a byte-wide bus writes the ratio in two steps. The first write goes to the lower byte. The second write goes to the upper byte, which carries three significant bits. Only the upper-byte write moves the complete 11-bit value into the counter, so the counter never sees a half-written ratio.

Writes are honoured only while the loop is switched off. A write made while the loop runs is dropped. Both addresses are write-only and always read back as zero. Any committed value below two runs as two. The counter steps from 0 to N-1 and raises a single-cycle pulse on its last count. It starts again from zero in the cycle after each commit.

Top module: `clkdiv_ratio_reg`

## Requirements
- R1: After reset the lower byte holds 0x02, and the counter runs with a ratio of two, so `div_tick` pulses every second cycle.
- R2: A write with `bus_sel`=0 (the lower byte) changes only the staged byte. The divider period stays the same until the next upper-byte write.
- R3: A write with `bus_sel`=1 (the upper byte) commits {wdata[2:0], staged lower byte} at that clock edge. The counter holds 0 in the next cycle, and its first pulse comes N cycles after the commit edge.
- R4: Bits 7:3 of an upper-byte write have no effect on the committed ratio.
- R5: A committed value of 0 or 1 runs as a ratio of two.
- R6: While `loop_en`=1, writes to either byte are discarded. Neither the staged lower byte nor the running ratio changes.
- R7: `bus_rdata` is 0x00 after a read at either address and at all other times.
- R8: `div_tick` is a single-cycle pulse that repeats every N cycles for a committed ratio N.
- R9: If the upper byte is written before the lower byte, the commit uses the previously staged lower byte. A later lower-byte write does not change the running ratio.
- R10: The largest ratio, 2047 (lower 0xFF, upper 0x07), gives a period of 2047 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en | input | 1 | Loop running; 1 blocks ratio writes |
| bus_sel | input | 1 | Address bit: 0 lower byte, 1 upper byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, always zero |
| div_tick | output | 1 | Terminal-count pulse of the divide-by-N counter |

## Verification
The in-RTL assertions check on every cycle the following rules:
- the running ratio holds steady while the loop is enabled and across lower-byte writes
- the ratio never drops below two
- the count stays below the ratio
- the count is zero in the cycle after a commit
- the pulse is never longer than one cycle

Some behaviours only the bench's scenarios can show:
- the exact period that results from a given write sequence
- the masking of the upper five data bits
- the stale lower byte when the bytes are written out of order
- the full 2047-cycle period
- the zero read-back

A behavioural reference model in the bench also follows the expected pulse on every clock.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  localparam int CDR_RATIO_W = 11;
  localparam int CDR_BYTE_W  = 8;
  localparam int CDR_MIN     = 2;

  // Raise any ratio under the floor to the floor.
  function automatic logic [CDR_RATIO_W-1:0] clamp_ratio(input logic [CDR_RATIO_W-1:0] raw);
    if (raw < CDR_RATIO_W'(CDR_MIN)) return CDR_RATIO_W'(CDR_MIN);
    return raw;
  endfunction

  // Join the upper bits with the staged lower byte.
  function automatic logic [CDR_RATIO_W-1:0] join_ratio(input logic [CDR_BYTE_W-1:0] hi,
                                                        input logic [CDR_BYTE_W-1:0] lo);
    return {hi[CDR_RATIO_W-CDR_BYTE_W-1:0], lo};
  endfunction
endpackage

// File: rtl/cdr_regs.sv
module cdr_regs
  import cdr_pkg::*;
#(
  parameter int RATIO_W = CDR_RATIO_W,
  parameter int BYTE_W  = CDR_BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               loop_en,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [BYTE_W-1:0]  bus_wdata,
  output logic [RATIO_W-1:0] ratio_q,
  output logic               commit_o
);
  localparam logic [BYTE_W-1:0]  LO_RST    = BYTE_W'(CDR_MIN);
  localparam logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(CDR_MIN);

  logic [BYTE_W-1:0] lo_q;
  logic              lo_wr_w;

  assign lo_wr_w  = bus_wr & ~bus_sel & ~loop_en;
  assign commit_o = bus_wr &  bus_sel & ~loop_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= LO_RST;
      ratio_q <= RATIO_RST;
    end else begin
      if (lo_wr_w)  lo_q    <= bus_wdata;
      if (commit_o) ratio_q <= clamp_ratio(join_ratio(bus_wdata, lo_q));
    end
  end

  // R6: an enabled loop freezes the staged byte and the running ratio
  assert_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> ($stable(ratio_q) && $stable(lo_q)));
  // R2: a lower-byte write leaves the running ratio alone
  assert_lo_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel) |=> $stable(ratio_q));
  // R5: the running ratio never falls under the floor
  assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_q >= RATIO_W'(CDR_MIN));
endmodule

// File: rtl/cdr_counter.sv
module cdr_counter
  import cdr_pkg::*;
#(
  parameter int RATIO_W = CDR_RATIO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               restart,
  output logic               tick
);
  logic [RATIO_W-1:0] cnt_q;
  logic               last_w;

  assign last_w = (cnt_q == ratio - RATIO_W'(1));
  assign tick   = last_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (restart)     cnt_q <= '0;
    else if (last_w)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + RATIO_W'(1);
  end

  // R8: the count stays inside 0..N-1
  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio);
  // R8: the terminal pulse lasts one cycle
  assert_one_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R3: a commit restarts the count
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/clkdiv_ratio_reg.sv
module clkdiv_ratio_reg
  import cdr_pkg::*;
#(
  parameter int RATIO_W = CDR_RATIO_W,
  parameter int BYTE_W  = CDR_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              div_tick
);
  logic [RATIO_W-1:0] ratio_w;
  logic               commit_w;
  logic [BYTE_W-1:0]  rdata_q;

  cdr_regs #(.RATIO_W(RATIO_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .ratio_q(ratio_w), .commit_o(commit_w)
  );

  cdr_counter #(.RATIO_W(RATIO_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ratio(ratio_w), .restart(commit_w), .tick(div_tick)
  );

  // Write-only registers: the read port returns zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= '0;
  end
  assign bus_rdata = rdata_q;
endmodule

// File: tb/tb_clkdiv_ratio_reg.sv
module tb_clkdiv_ratio_reg;
  logic clk = 0, rst_n = 0, loop_en = 0, bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic div_tick;
  int total = 0, bad = 0;
  string cur_req = "R1";

  int m_lo, m_ratio, m_cnt;

  always #10 clk = ~clk;

  clkdiv_ratio_reg dut (.clk(clk), .rst_n(rst_n), .loop_en(loop_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .div_tick(div_tick));

  // Behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 2; m_ratio = 2; m_cnt = 0;
    end else begin
      if (bus_wr && bus_sel && !loop_en) begin
        m_ratio = (bus_wdata % 8) * 256 + m_lo;
        if (m_ratio < 2) m_ratio = 2;
        m_cnt = 0;
      end else if (m_cnt == m_ratio - 1) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      if (bus_wr && !bus_sel && !loop_en) m_lo = bus_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(div_tick === (m_cnt == m_ratio - 1), cur_req, int'(div_tick), int'(m_cnt == m_ratio - 1));
      chk(bus_rdata === 8'h00, "R7", int'(bus_rdata), 0);
    end
  end

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk); bus_sel = sel; bus_wr = 1; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic period(input int exp, input string req);
    int n = 0;
    @(negedge clk);
    while (div_tick !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (div_tick !== 1'b1 && n < 5000);
    chk(n == exp, req, n, exp);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";  period(2, "R1");
    cur_req = "R2";  wr(0, 8'h05); period(2, "R2");
    cur_req = "R3";  wr(1, 8'h00); period(5, "R3");
    cur_req = "R4";  wr(0, 8'h10); wr(1, 8'hF9); period(272, "R4");
    cur_req = "R5";  wr(0, 8'h00); wr(1, 8'h00); period(2, "R5");
    wr(0, 8'h01); wr(1, 8'h00); period(2, "R5");
    cur_req = "R6";  wr(0, 8'h07); wr(1, 8'h00); period(7, "R6");
    @(negedge clk); loop_en = 1;
    wr(0, 8'h30); wr(1, 8'h02); period(7, "R6");
    @(negedge clk); loop_en = 0;
    wr(1, 8'h00); period(7, "R6");
    cur_req = "R9";  wr(1, 8'h01); wr(0, 8'h20); period(263, "R9");
    cur_req = "R7";
    @(negedge clk); bus_rd = 1; bus_sel = 0;
    @(negedge clk); bus_sel = 1;
    @(negedge clk); bus_rd = 0;
    chk(bus_rdata === 8'h00, "R7", int'(bus_rdata), 0);
    cur_req = "R10"; wr(0, 8'hFF); wr(1, 8'h07); period(2047, "R10");
    cur_req = "R8";  wr(0, 8'h03); wr(1, 8'h00); period(3, "R8");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule